// File: doc/BRIEF.md
# Trimmed Line Output Formatter

This block holds one print line of 120 character positions and, when told that the line is complete, turns it into a byte stream. It first looks for the highest position that holds something other than a blank. It then streams positions 0 up to that position in ascending order, so trailing blanks never leave the block. Once the line is out, every position returns to the blank code, ready for the next line.

The block also turns a paper-advance request into a short run of control bytes, chosen by a 2-bit channel number. If the line strobe and the advance request arrive together, the line bytes go out first and the control bytes follow. Bytes leave on a valid/ready handshake. A busy flag covers the whole service. A one-cycle done pulse marks its end.

Characters are loaded through a simple write port while the block is idle. Capturing scan data into that port is the job of surrounding logic.

Top module: `line_trim_emitter`

## Requirements
- R1: After reset, out_valid_o, busy_o and done_o are low, and every position reads as the blank code 0x20, so a first line strobe emits no bytes.
- R2: While busy_o is low, a cycle with wr_en_i high stores wr_char_i at position wr_pos_i (0 to 119).
- R3: A line strobe emits positions 0 through the highest non-blank position in ascending order, including blanks inside that range.
- R4: A line made only of blanks emits no bytes. The scan from position 119 down to position 0 takes one cycle per position, so done_o is high in the 122nd cycle after the strobe edge.
- R5: An advance request emits control bytes chosen by adv_chan_i. Channel 0 gives 0x0D. Channel 1 gives 0x0A. Channel 2 gives 0x0A then 0x0C. Channel 3 gives 0x0A.
- R6: When line_done_i and adv_req_i are high in the same cycle, all line bytes are emitted before the advance bytes.
- R7: While out_valid_o is high and out_ready_i is low, the next cycle keeps out_valid_o high and out_data_o unchanged.
- R8: After a line has been emitted, every position is blank again. An advance-only request leaves the stored characters unchanged.
- R9: busy_o rises in the cycle after an accepted request and stays high through the single-cycle done_o pulse, then falls. Line strobes, advance requests and writes made while busy_o is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write one character into the line |
| wr_pos_i | input | 7 | Position written (0 to 119) |
| wr_char_i | input | 8 | Character written |
| line_done_i | input | 1 | Line-complete strobe |
| adv_req_i | input | 1 | Paper-advance request |
| adv_chan_i | input | 2 | Advance channel |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Downstream accepts the byte |
| out_data_o | output | 8 | Output byte |
| done_o | output | 1 | One-cycle pulse at the end of a service |
| busy_o | output | 1 | Service in progress |

## Verification
The line-complete strobe and the advance request can be sampled on the same clock edge. The bench provokes this by raising both in one cycle, once on a line with content and once on an idle block. A behavioural model queues the trimmed line bytes ahead of the channel's control bytes, and every handshake on the stream is compared against that queue. An advance-only service is followed by a fresh line strobe, which shows that the stored characters survived.

// File: rtl/lto_pkg.sv
`timescale 1ns/1ps
package lto_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_SCAN, ST_EMIT, ST_ADV, ST_FILL, ST_FIN
   } lto_state_e;

   localparam logic [7:0] CODE_CR = 8'h0D;
   localparam logic [7:0] CODE_LF = 8'h0A;
   localparam logic [7:0] CODE_FF = 8'h0C;

   // control byte for a channel at a given step of its sequence
   function automatic logic [7:0] adv_code(input logic [1:0] ch, input logic step);
      case (ch)
         2'd0:    return CODE_CR;
         2'd2:    return step ? CODE_FF : CODE_LF;
         default: return CODE_LF;
      endcase
   endfunction

   // only channel 2 carries a second byte
   function automatic logic adv_is_last(input logic [1:0] ch, input logic step);
      return (ch != 2'd2) || step;
   endfunction
endpackage

// File: rtl/lto_store.sv
`timescale 1ns/1ps
module lto_store #(
   parameter int DEPTH = 120,
   parameter int DW = 8,
   parameter int AW = $clog2(DEPTH),
   parameter logic [DW-1:0] BLANK = 8'h20,
   parameter bit FAST_FILL = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata,
   input  logic          clr,
   input  logic [AW-1:0] clr_addr
);
   logic [DW-1:0] mem [DEPTH];

   generate
      if (FAST_FILL) begin : g_bitmap
         // a position reads blank unless written since the last clear
         logic [DEPTH-1:0] vld;
         logic unused_clr_addr;
         assign unused_clr_addr = ^clr_addr;

         always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wdata;
         end

         always_ff @(posedge clk) begin
            if (!rst_n || clr) vld <= '0;
            else if (we)       vld[waddr] <= 1'b1;
         end

         assign rdata = vld[raddr] ? mem[raddr] : BLANK;
      end else begin : g_walk
         // one blank written per cycle during the fill
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= BLANK;
            end else if (clr) begin
               mem[clr_addr] <= BLANK;
            end else if (we) begin
               mem[waddr] <= wdata;
            end
         end

         assign rdata = mem[raddr];
      end
   endgenerate
endmodule

// File: rtl/lto_adv_rom.sv
`timescale 1ns/1ps
module lto_adv_rom import lto_pkg::*; #(
   parameter int DW = 8
) (
   input  logic [1:0]    chan,
   input  logic          step,
   output logic [DW-1:0] code,
   output logic          last
);
   assign code = DW'(adv_code(chan, step));
   assign last = adv_is_last(chan, step);
endmodule

// File: rtl/lto_ctrl.sv
`timescale 1ns/1ps
module lto_ctrl import lto_pkg::*; #(
   parameter int DEPTH = 120,
   parameter int DW = 8,
   parameter int AW = $clog2(DEPTH),
   parameter logic [DW-1:0] BLANK = 8'h20,
   parameter bit FAST_FILL = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          line_go,
   input  logic          adv_go,
   input  logic [1:0]    adv_chan,
   input  logic [DW-1:0] rd_char,
   input  logic [DW-1:0] rom_code,
   input  logic          rom_last,
   input  logic          out_ready,
   output logic [AW-1:0] rd_addr,
   output logic          clr,
   output logic [AW-1:0] clr_addr,
   output logic [1:0]    rom_chan,
   output logic          rom_step,
   output logic          out_valid,
   output logic [DW-1:0] out_data,
   output logic          busy,
   output logic          done
);
   localparam logic [AW-1:0] TOP_POS = AW'(DEPTH - 1);

   lto_state_e    st;
   logic [AW-1:0] cur, last, fill_cnt;
   logic          adv_pend, line_act, step;
   logic [1:0]    chan_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= ST_IDLE;
         cur <= '0;
         last <= '0;
         fill_cnt <= '0;
         adv_pend <= 1'b0;
         line_act <= 1'b0;
         step <= 1'b0;
         chan_q <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               step <= 1'b0;
               if (line_go) begin
                  st <= ST_SCAN;
                  cur <= TOP_POS;
                  line_act <= 1'b1;
                  adv_pend <= adv_go;
                  chan_q <= adv_chan;
               end else if (adv_go) begin
                  st <= ST_ADV;
                  line_act <= 1'b0;
                  adv_pend <= 1'b0;
                  chan_q <= adv_chan;
               end
            end
            ST_SCAN: begin
               if (rd_char != BLANK) begin
                  last <= cur;
                  cur <= '0;
                  st <= ST_EMIT;
               end else if (cur == '0) begin
                  st <= adv_pend ? ST_ADV : ST_FILL;
               end else begin
                  cur <= cur - 1'b1;
               end
            end
            ST_EMIT: begin
               if (out_ready) begin
                  if (cur == last) st <= adv_pend ? ST_ADV : ST_FILL;
                  else             cur <= cur + 1'b1;
               end
            end
            ST_ADV: begin
               if (out_ready) begin
                  if (rom_last) st <= line_act ? ST_FILL : ST_FIN;
                  else          step <= 1'b1;
               end
            end
            ST_FILL: begin
               if (FAST_FILL || fill_cnt == TOP_POS) begin
                  st <= ST_FIN;
                  fill_cnt <= '0;
               end else begin
                  fill_cnt <= fill_cnt + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign rd_addr   = cur;
   assign clr       = (st == ST_FILL);
   assign clr_addr  = fill_cnt;
   assign rom_chan  = chan_q;
   assign rom_step  = step;
   assign out_valid = (st == ST_EMIT) || (st == ST_ADV);
   assign out_data  = (st == ST_EMIT) ? rd_char : rom_code;
   assign busy      = (st != ST_IDLE);
   assign done      = (st == ST_FIN);

   AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data)); // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy); // R9
   AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> busy); // R9
   AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> cur <= TOP_POS); // R3
   AST_LAST_NONBLANK: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_EMIT) && (cur == last) |-> rd_char != BLANK); // R3
   AST_ADV_AFTER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ADV) |=> (st != ST_EMIT) && (st != ST_SCAN)); // R6
endmodule

// File: rtl/line_trim_emitter.sv
`timescale 1ns/1ps
module line_trim_emitter #(
   parameter int LINE_LEN = 120,
   parameter int CHAR_W = 8,
   parameter logic [CHAR_W-1:0] BLANK_CODE = 8'h20,
   parameter bit FAST_FILL = 1'b1,
   localparam int AW = $clog2(LINE_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [AW-1:0]     wr_pos_i,
   input  logic [CHAR_W-1:0] wr_char_i,
   input  logic              line_done_i,
   input  logic              adv_req_i,
   input  logic [1:0]        adv_chan_i,
   output logic              out_valid_o,
   input  logic              out_ready_i,
   output logic [CHAR_W-1:0] out_data_o,
   output logic              done_o,
   output logic              busy_o
);
   generate
      if (LINE_LEN < 2) begin : g_bad_len
         $error("LINE_LEN must be at least 2");
      end
      if (CHAR_W < 8) begin : g_bad_width
         $error("CHAR_W must hold the 8-bit control codes");
      end
   endgenerate

   logic [AW-1:0]     rd_addr, clr_addr;
   logic [CHAR_W-1:0] rd_char, rom_code;
   logic              clr, rom_last, rom_step;
   logic [1:0]        rom_chan;

   lto_store #(.DEPTH(LINE_LEN), .DW(CHAR_W), .AW(AW), .BLANK(BLANK_CODE),
               .FAST_FILL(FAST_FILL)) u_store (
      .clk(clk), .rst_n(rst_n),
      .we(wr_en_i && !busy_o), .waddr(wr_pos_i), .wdata(wr_char_i),
      .raddr(rd_addr), .rdata(rd_char),
      .clr(clr), .clr_addr(clr_addr)
   );

   lto_adv_rom #(.DW(CHAR_W)) u_rom (
      .chan(rom_chan), .step(rom_step), .code(rom_code), .last(rom_last)
   );

   lto_ctrl #(.DEPTH(LINE_LEN), .DW(CHAR_W), .AW(AW), .BLANK(BLANK_CODE),
              .FAST_FILL(FAST_FILL)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .line_go(line_done_i), .adv_go(adv_req_i), .adv_chan(adv_chan_i),
      .rd_char(rd_char), .rom_code(rom_code), .rom_last(rom_last),
      .out_ready(out_ready_i),
      .rd_addr(rd_addr), .clr(clr), .clr_addr(clr_addr),
      .rom_chan(rom_chan), .rom_step(rom_step),
      .out_valid(out_valid_o), .out_data(out_data_o),
      .busy(busy_o), .done(done_o)
   );
endmodule

// File: tb/line_trim_emitter_tb.sv
`timescale 1ns/1ps
module line_trim_emitter_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en_i = 1'b0;
   logic [6:0] wr_pos_i = '0;
   logic [7:0] wr_char_i = '0;
   logic       line_done_i = 1'b0;
   logic       adv_req_i = 1'b0;
   logic [1:0] adv_chan_i = '0;
   logic       out_ready_i = 1'b1;
   logic       out_valid_o, done_o, busy_o;
   logic [7:0] out_data_o;

   always #2.5 clk = ~clk;

   line_trim_emitter dut_i (.*);

   int total = 0;
   int bad = 0;
   logic [7:0] mdl [120];
   logic [7:0] exp_q [$];
   logic       prev_v = 1'b0, prev_r = 1'b0;
   logic [7:0] prev_d = '0;
   logic       thr = 1'b0;
   logic [7:0] lf = 8'h5a;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // ready driven just after the rising edge
   always @(posedge clk) begin
      #1;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      out_ready_i = thr ? lf[0] : 1'b1;
   end

   // reference comparison on every clock
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_v && !prev_r)
            chk(out_valid_o && out_data_o == prev_d, "R7 hold",
                {out_valid_o, out_data_o}, {1'b1, prev_d});
         if (out_valid_o && out_ready_i) begin
            if (exp_q.size() == 0) chk(1'b0, "R9 unexpected byte", out_data_o, 0);
            else begin
               logic [7:0] e;
               e = exp_q.pop_front();
               chk(out_data_o == e, "R3/R5/R6 byte", out_data_o, e);
            end
         end
      end
      prev_v = out_valid_o;
      prev_r = out_ready_i;
      prev_d = out_data_o;
   end

   task automatic put(input int pos, input logic [7:0] ch);
      @(negedge clk);
      wr_en_i = 1'b1; wr_pos_i = 7'(pos); wr_char_i = ch;
      @(negedge clk);
      wr_en_i = 1'b0;
      mdl[pos] = ch;
   endtask

   task automatic push_adv(input int ch);
      if (ch == 0) exp_q.push_back(8'h0D);
      else exp_q.push_back(8'h0A);
      if (ch == 2) exp_q.push_back(8'h0C);
   endtask

   task automatic start(input bit ln, input bit adv, input int ch);
      @(negedge clk);
      line_done_i = ln; adv_req_i = adv; adv_chan_i = 2'(ch);
      if (ln) begin
         int hi;
         hi = -1;
         for (int i = 119; i >= 0; i--) if (mdl[i] != 8'h20) begin hi = i; break; end
         for (int i = 0; i <= hi; i++) exp_q.push_back(mdl[i]);
         for (int i = 0; i < 120; i++) mdl[i] = 8'h20;
      end
      if (adv) push_adv(ch);
      @(negedge clk);
      line_done_i = 1'b0; adv_req_i = 1'b0;
      chk(busy_o == 1'b1, "R9 busy rise", busy_o, 1);
   endtask

   task automatic finish(output int n);
      n = 1;
      while (!done_o && n < 5000) begin @(negedge clk); n++; end
      chk(done_o == 1'b1, "R9 done seen", done_o, 1);
      chk(exp_q.size() == 0, "R3/R5 all bytes out", exp_q.size(), 0);
      @(negedge clk);
      chk(busy_o == 1'b0 && done_o == 1'b0, "R9 busy fall", {busy_o, done_o}, 0);
   endtask

   initial begin
      #750000;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n;
      for (int i = 0; i < 120; i++) mdl[i] = 8'h20;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!out_valid_o && !busy_o && !done_o, "R1 reset outputs",
          {out_valid_o, busy_o, done_o}, 0);

      // R1 R4: empty line, exact duration of the full scan
      start(1, 0, 0); finish(n);
      chk(n == 122, "R4 blank-line duration", n, 122);

      // R2 R3: interior blanks kept, trailing ones dropped
      put(0, 8'h48); put(1, 8'h45); put(2, 8'h4C); put(3, 8'h4C); put(4, 8'h4F);
      put(10, 8'h58);
      start(1, 0, 0); finish(n);

      // R8: store cleared after a line
      start(1, 0, 0); finish(n);
      chk(n == 122, "R8 cleared store gives blank line", n, 122);

      // R3 R7: both ends of the line under throttled ready
      thr = 1'b1;
      put(0, 8'h41); put(119, 8'h42); put(60, 8'h43);
      start(1, 0, 0); finish(n);
      put(0, 8'h5A);
      start(1, 0, 0); finish(n);
      thr = 1'b0;

      // R5: every channel alone
      for (int c = 0; c < 4; c++) begin start(0, 1, c); finish(n); end
      thr = 1'b1;
      start(0, 1, 2); finish(n);
      thr = 1'b0;

      // R8: advance-only keeps stored characters
      put(3, 8'h41);
      start(0, 1, 1); finish(n);
      start(1, 0, 0); finish(n);

      // R6: line and advance in the same cycle
      put(2, 8'h5A);
      start(1, 1, 2); finish(n);
      start(1, 1, 0); finish(n);

      // R9: requests and writes while busy are ignored
      put(119, 8'h4B);
      start(1, 0, 0);
      repeat (3) @(negedge clk);
      line_done_i = 1'b1; adv_req_i = 1'b1; adv_chan_i = 2'd2;
      wr_en_i = 1'b1; wr_pos_i = 7'd5; wr_char_i = 8'h51;
      @(negedge clk);
      line_done_i = 1'b0; adv_req_i = 1'b0; wr_en_i = 1'b0;
      finish(n);
      repeat (4) @(negedge clk);
      chk(!out_valid_o && !busy_o, "R9 no late service", {out_valid_o, busy_o}, 0);
      start(1, 0, 0); finish(n);
      chk(n == 122, "R9 busy write dropped", n, 122);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule